// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the memory-mapped register bank for one descriptor-driven DMA/XOR channel. Software reaches it over a simple 32-bit register bus with a one-cycle select, a write flag, a byte address and write data. Read data is returned in the same cycle. Through this bus software enables the channel, resumes a chain, programs the next-descriptor link, and reads the address of the descriptor the engine is working on.

The channel engine sits on the other side. It receives a level enable, a one-cycle resume pulse and the next-descriptor link. It reports a live busy level, the current descriptor address, and single-cycle pulses for transfer done, chain done and four kinds of fault. The block turns these pulses into sticky status bits, which software clears by writing 1 to them. It drives one interrupt line that is the OR of the pending conditions. A transfer-done event raises the interrupt only when the descriptor that produced it asked for an interrupt.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset the control register, the sticky status bits and the next-descriptor register all read 0, and `irqOut`, `engEnable` and `engAppend` are low.
- R2: Bit 0 of the control register at offset 0x00 is read/write. Its value drives `engEnable`, and writing 0 to it disables the channel.
- R3: A write to offset 0x00 with bit 1 set drives `engAppend` high for exactly the cycle after the write. Bit 1 always reads back as 0.
- R4: Status bit 13 at offset 0x04 and the output `chanBusy` follow `engBusy` live. Writes to the status register do not change them.
- R5: Status bit 12 latches a pulse on `engEotPulse` and status bit 11 latches a pulse on `engEocPulse`. Each stays set until 1 is written to its bit position.
- R6: The fault bits latch their pulses and clear when 1 is written to them: parity at bit 9, memory-controller abort at bit 5, target abort at bit 4 and master abort at bit 3.
- R7: Writing 0 to a sticky status bit leaves it unchanged. Clearing one bit leaves the other bits unchanged.
- R8: When an event pulse arrives in the same cycle as a write-1 clear of its bit, the bit stays set.
- R9: Offset 0x08 reads `engCurDesc`, and writes to it have no effect.
- R10: Offset 0x24 is a 32-bit read/write next-descriptor register that drives `nextDesc`. It changes only when written.
- R11: `irqOut` is high while any sticky fault bit or the chain-done bit is set. The transfer-done bit contributes only if `engDescIrqEn` was high with one of the transfer-done pulses since the bit was last cleared.
- R12: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle; 0 when not reading |
| engEnable | output | 1 | Channel enable level |
| engAppend | output | 1 | One-cycle resume pulse |
| nextDesc | output | 32 | Next-descriptor link |
| chanBusy | output | 1 | Live busy indication |
| irqOut | output | 1 | Channel interrupt |
| engBusy | input | 1 | Engine busy level |
| engCurDesc | input | 32 | Address of descriptor in progress |
| engDescIrqEn | input | 1 | Active descriptor requests interrupt |
| engEotPulse | input | 1 | Transfer-done pulse |
| engEocPulse | input | 1 | Chain-done pulse |
| engErrParity | input | 1 | Internal parity fault pulse |
| engErrMemAbort | input | 1 | Memory-controller abort pulse |
| engErrTgtAbort | input | 1 | Internal target abort pulse |
| engErrMstAbort | input | 1 | Internal master abort pulse |

## Verification
The assertions assume that each engine event input is a single-cycle pulse sampled at the clock edge. They also assume that `engDescIrqEn` is valid in the same cycle as a transfer-done pulse. The bench raises every event for one cycle only. It holds the interrupt-enable flag steady across the pulse, and it raises some events while a bus write clears the same bit, to exercise the case where the event wins.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int DW = 32;

  // register byte offsets
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_CUR  = 8'h08;
  localparam logic [7:0] OFS_NEXT = 8'h24;

  // control bit positions
  localparam int B_EN  = 0;
  localparam int B_APP = 1;

  // status bit positions
  localparam int B_BUSY = 13;
  localparam int B_EOT  = 12;
  localparam int B_EOC  = 11;
  localparam int B_PAR  = 9;
  localparam int B_MCA  = 5;
  localparam int B_TAB  = 4;
  localparam int B_MAB  = 3;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTRL, RD_STAT, RD_CUR, RD_NEXT
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrStat;
    logic   wrNext;
    rdSel_e rdSel;
  } csrStrobe_t;
endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output csrStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(OFS_CUR);
  localparam logic [ADDR_W-1:0] A_NEXT = ADDR_W'(OFS_NEXT);

  logic doWr, doRd;
  assign doWr = busSel && busWr;
  assign doRd = busSel && !busWr;

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = RD_NONE;
    if (doWr) begin
      strobe.wrCtrl = (busAddr == A_CTRL);
      strobe.wrStat = (busAddr == A_STAT);
      strobe.wrNext = (busAddr == A_NEXT);
    end
    if (doRd) begin
      unique case (busAddr)
        A_CTRL:  strobe.rdSel = RD_CTRL;
        A_STAT:  strobe.rdSel = RD_STAT;
        A_CUR:   strobe.rdSel = RD_CUR;
        A_NEXT:  strobe.rdSel = RD_NEXT;
        default: strobe.rdSel = RD_NONE;
      endcase
    end
  end

  // R12: at most one register written per access, none on a read
  p_single_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrCtrl, strobe.wrStat, strobe.wrNext}));
  p_read_no_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |-> !(strobe.wrCtrl || strobe.wrStat || strobe.wrNext));
endmodule

// File: rtl/dma_csr_dp.sv
module dma_csr_dp
  import dma_csr_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  csrStrobe_t    strobe,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  output logic          engEnable,
  output logic          engAppend,
  output logic [DW-1:0] nextDesc,
  output logic          irqOut,
  input  logic          engBusy,
  input  logic [DW-1:0] engCurDesc,
  input  logic          engDescIrqEn,
  input  logic          engEotPulse,
  input  logic          engEocPulse,
  input  logic          engErrParity,
  input  logic          engErrMemAbort,
  input  logic          engErrTgtAbort,
  input  logic          engErrMstAbort
);
  localparam int NSTK = 6;
  // sticky index order: eot, eoc, par, mca, tab, mab
  localparam int STK_POS [NSTK] = '{B_EOT, B_EOC, B_PAR, B_MCA, B_TAB, B_MAB};

  logic            enQ, appendQ, eotArmQ;
  logic [DW-1:0]   nextQ;
  logic [NSTK-1:0] stkQ, evIn, clrReq;
  logic [DW-1:0]   statWord;

  assign evIn = {engEotPulse, engEocPulse, engErrParity,
                 engErrMemAbort, engErrTgtAbort, engErrMstAbort};

  generate
    for (genvar i = 0; i < NSTK; i++) begin : g_sticky
      assign clrReq[i] = strobe.wrStat && busWdata[STK_POS[i]];
      always_ff @(posedge clk) begin
        if (!rstN)           stkQ[NSTK-1-i] <= 1'b0;
        else if (evIn[NSTK-1-i]) stkQ[NSTK-1-i] <= 1'b1;
        else if (clrReq[i])  stkQ[NSTK-1-i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ     <= 1'b0;
      appendQ <= 1'b0;
      nextQ   <= '0;
      eotArmQ <= 1'b0;
    end else begin
      appendQ <= strobe.wrCtrl && busWdata[B_APP];
      if (strobe.wrCtrl) enQ   <= busWdata[B_EN];
      if (strobe.wrNext) nextQ <= busWdata;
      if (engEotPulse)   eotArmQ <= eotArmQ || engDescIrqEn;
      else if (clrReq[0]) eotArmQ <= 1'b0;
    end
  end

  always_comb begin
    statWord = '0;
    statWord[B_BUSY] = engBusy;
    for (int i = 0; i < NSTK; i++) statWord[STK_POS[i]] = stkQ[NSTK-1-i];
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_CTRL: busRdata = DW'(enQ);
      RD_STAT: busRdata = statWord;
      RD_CUR:  busRdata = engCurDesc;
      RD_NEXT: busRdata = nextQ;
      default: busRdata = '0;
    endcase
  end

  assign engEnable = enQ;
  assign engAppend = appendQ;
  assign nextDesc  = nextQ;
  assign irqOut    = (stkQ[NSTK-1] && eotArmQ) || (|stkQ[NSTK-2:0]);

  p_append_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    engAppend |=> !engAppend);
  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    engEotPulse |=> stkQ[NSTK-1]);
  p_zero_write_keeps_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStat && !busWdata[B_EOC] && stkQ[NSTK-2]) |=> stkQ[NSTK-2]);
  p_fault_irq_r11: assert property (@(posedge clk) disable iff (!rstN)
    (engErrParity || engErrMemAbort || engErrTgtAbort || engErrMstAbort) |=> irqOut);
  p_next_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrNext |=> $stable(nextDesc));
  p_busy_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSel == RD_STAT) |-> (busRdata[B_BUSY] == engBusy));
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              engEnable,
  output logic              engAppend,
  output logic [31:0]       nextDesc,
  output logic              chanBusy,
  output logic              irqOut,
  input  logic              engBusy,
  input  logic [31:0]       engCurDesc,
  input  logic              engDescIrqEn,
  input  logic              engEotPulse,
  input  logic              engEocPulse,
  input  logic              engErrParity,
  input  logic              engErrMemAbort,
  input  logic              engErrTgtAbort,
  input  logic              engErrMstAbort
);
  csrStrobe_t strobe;

  dma_csr_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .strobe(strobe)
  );

  dma_csr_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .engEnable(engEnable), .engAppend(engAppend),
    .nextDesc(nextDesc), .irqOut(irqOut), .engBusy(engBusy),
    .engCurDesc(engCurDesc), .engDescIrqEn(engDescIrqEn),
    .engEotPulse(engEotPulse), .engEocPulse(engEocPulse),
    .engErrParity(engErrParity), .engErrMemAbort(engErrMemAbort),
    .engErrTgtAbort(engErrTgtAbort), .engErrMstAbort(engErrMstAbort)
  );

  assign chanBusy = engBusy;

  p_busy_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(engBusy) |-> chanBusy);
endmodule

// File: tb/test_dma_chan_csr.sv
`timescale 1ns/100ps
module test_dma_chan_csr;
  logic clk = 0, rstN = 0;
  logic busSel = 0, busWr = 0;
  logic [7:0]  busAddr = 0;
  logic [31:0] busWdata = 0, busRdata, nextDesc, engCurDesc = 32'h1234_5670;
  logic engEnable, engAppend, chanBusy, irqOut;
  logic engBusy = 0, engDescIrqEn = 0;
  logic [5:0] ev = 0; // eot, eoc, par, mca, tab, mab

  int nChk = 0, nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_chan_csr i_dma_chan_csr (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .engEnable(engEnable),
    .engAppend(engAppend), .nextDesc(nextDesc), .chanBusy(chanBusy),
    .irqOut(irqOut), .engBusy(engBusy), .engCurDesc(engCurDesc),
    .engDescIrqEn(engDescIrqEn), .engEotPulse(ev[5]), .engEocPulse(ev[4]),
    .engErrParity(ev[3]), .engErrMemAbort(ev[2]), .engErrTgtAbort(ev[1]),
    .engErrMstAbort(ev[0])
  );

  typedef struct packed {
    logic        sel, wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [5:0]  ev;
    logic        irqEn;
    logic [31:0] expRd;
    logic        expIrq, chkRd;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{1,0,8'h00,32'h0,6'h00,0,32'h0,0,1},          // R2 ctrl 0
    '{1,1,8'h00,32'h1,6'h00,0,32'h0,0,0},          // R2 enable
    '{1,0,8'h00,32'h0,6'h00,0,32'h1,0,1},          // R2 readback
    '{1,1,8'h24,32'hA5A5_0040,6'h00,0,32'h0,0,0},  // R10
    '{1,0,8'h24,32'h0,6'h00,0,32'hA5A5_0040,0,1},  // R10
    '{1,0,8'h08,32'h0,6'h00,0,32'h1234_5670,0,1},  // R9
    '{1,1,8'h08,32'hFFFF_FFFF,6'h00,0,32'h0,0,0},  // R9 write ignored
    '{1,0,8'h08,32'h0,6'h00,0,32'h1234_5670,0,1},  // R9
    '{0,0,8'h00,32'h0,6'h20,0,32'h0,0,0},          // R11 eot w/o irq enable
    '{1,0,8'h04,32'h0,6'h00,0,32'h1000,0,1},       // R5
    '{1,1,8'h04,32'h1000,6'h00,0,32'h0,0,0},       // R5 clear
    '{1,0,8'h04,32'h0,6'h00,0,32'h0,0,1},          // R5
    '{0,0,8'h00,32'h0,6'h20,1,32'h0,1,0},          // R11 eot with irq enable
    '{1,0,8'h04,32'h0,6'h00,0,32'h1000,1,1},       // R5
    '{1,1,8'h04,32'h0,6'h00,0,32'h0,1,0},          // R7 write 0
    '{1,0,8'h04,32'h0,6'h00,0,32'h1000,1,1},       // R7
    '{0,0,8'h00,32'h0,6'h11,0,32'h0,1,0},          // R5 R6 eoc + mab
    '{1,0,8'h04,32'h0,6'h00,0,32'h1808,1,1},       // R6
    '{1,1,8'h04,32'h1808,6'h01,0,32'h0,1,0},       // R8 mab wins
    '{1,0,8'h04,32'h0,6'h00,0,32'h0008,1,1},       // R8 R7
    '{1,1,8'h04,32'h0008,6'h00,0,32'h0,0,0},       // R6 clear, R11 low
    '{0,0,8'h00,32'h0,6'h0E,0,32'h0,1,0},          // R6 par mca tab
    '{1,0,8'h04,32'h0,6'h00,0,32'h0230,1,1},       // R6
    '{1,1,8'h04,32'h0230,6'h00,0,32'h0,0,0},       // R6 clear
    '{1,0,8'h04,32'h0,6'h00,0,32'h0,0,1},          // R6
    '{1,0,8'h10,32'h0,6'h00,0,32'h0,0,1},          // R12 unmapped read
    '{1,1,8'h10,32'hFFFF_FFFF,6'h00,0,32'h0,0,0},  // R12 unmapped write
    '{1,0,8'h00,32'h0,6'h00,0,32'h1,0,1},          // R12 ctrl unchanged
    '{1,0,8'h24,32'h0,6'h00,0,32'hA5A5_0040,0,1}   // R12 next unchanged
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busSel = 1; busWr = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk); busSel = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWr = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    check("R1 irq", 32'(irqOut), 0);
    check("R1 enable", 32'(engEnable), 0);
    check("R1 append", 32'(engAppend), 0);
    rd(8'h00, d); check("R1 ctrl", d, 0);
    rd(8'h04, d); check("R1 status", d, 0);
    rd(8'h24, d); check("R1 next", d, 0);

    for (int i = 0; i < NV; i++) begin
      busSel = VEC[i].sel; busWr = VEC[i].wr; busAddr = VEC[i].addr;
      busWdata = VEC[i].data; ev = VEC[i].ev; engDescIrqEn = VEC[i].irqEn;
      #1;
      if (VEC[i].chkRd) check($sformatf("vec %0d rdata", i), busRdata, VEC[i].expRd);
      @(negedge clk);
      ev = 0; busSel = 0; busWr = 0; engDescIrqEn = 0;
      check($sformatf("R11 vec %0d irq", i), 32'(irqOut), 32'(VEC[i].expIrq));
    end
    check("R2 engEnable on", 32'(engEnable), 1);
    check("R10 nextDesc port", nextDesc, 32'hA5A5_0040);

    // R3 append pulse
    busSel = 1; busWr = 1; busAddr = 8'h00; busWdata = 32'h3;
    @(negedge clk); busSel = 0; busWr = 0;
    check("R3 append high", 32'(engAppend), 1);
    @(negedge clk);
    check("R3 append low", 32'(engAppend), 0);
    rd(8'h00, d); check("R3 append reads 0", d, 1);

    // R2 disable
    wr(8'h00, 32'h0);
    check("R2 engEnable off", 32'(engEnable), 0);

    // R4 busy
    engBusy = 1;
    rd(8'h04, d); check("R4 busy bit", d, 32'h2000);
    check("R4 chanBusy", 32'(chanBusy), 1);
    wr(8'h04, 32'h2000);
    rd(8'h04, d); check("R4 busy after write", d, 32'h2000);
    engBusy = 0;
    rd(8'h04, d); check("R4 busy clear", d, 0);
    check("R4 chanBusy low", 32'(chanBusy), 0);

    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule